// File: doc/BRIEF.md
# PRBS Receive Synchronizer and Bit Error Counter

This block is the receive half of a bit error rate tester. It takes a serial bit stream, one bit per accepted beat, and builds a local reference that follows the incoming pattern. The pattern is either a pseudorandom sequence with a programmable register length and feedback tap set of up to 32 stages, or a fixed word of 1 to 32 bits that repeats. The receive side has its own configuration inputs and its own beat qualifier, and it does not depend on any transmit generator.

While it has no sync, the reference history is filled straight from the received bits, and the block counts how many bits in a row match its prediction. After 32 matching bits in a row it declares lock. From then on the reference runs by itself. Each received bit is compared with the reference, and two saturating counters record the compared bits and the mismatched bits. If the error density gets too high, the block drops lock and starts acquisition again. The block can hold lock on streams with error rates up to about one in a hundred.

A host can pulse a strobe at any time. The strobe copies both live counters into holding registers and restarts the live counters in the same cycle, so no bit is lost between measurement intervals.

Top module: `prbs_sync_checker`

## Requirements
- R1: `in_ready` is always 1, so the source never sees back-pressure. A bit is taken on each rising clock edge where `in_valid` is 1. A cycle with `in_valid` at 0 is ignored entirely: it is not compared, not counted, and has no effect on sync state, whatever `in_bit` carries.
- R2: The prediction of each bit depends on `cfg_mode`. With `cfg_mode`=0 (pseudorandom), the prediction is the XOR of the bits received k+1 beats earlier, taken for every k with `cfg_taps[k]`=1 and k < `cfg_len`. With `cfg_mode`=1 (repeating word), the prediction is the bit received `cfg_len` beats earlier. `cfg_len` ranges from 1 to 32.
- R3: After reset, `sync_lost` is 1. During acquisition the reference history takes the received bits. `sync_lost` falls at the clock edge that takes the 32nd prediction-matching bit in a row. Any mismatch restarts the run.
- R4: While locked, the reference history takes its own predicted bits. Every accepted bit adds 1 to the bit count. Every accepted bit that differs from the prediction adds 1 to the error count, so one inverted bit costs exactly one error. The error count never exceeds the bit count.
- R5: While locked, lock is kept as long as fewer than 6 errors fall within the most recent 64 compared bits. At the edge that takes the bit making 6 errors within 64, `sync_lost` rises and acquisition restarts. That bit is still counted.
- R6: While `sync_lost` is 1, neither live counter changes, except for the clear caused by a strobe.
- R7: On an edge with `snap_strobe`=1, `snap_bits`/`snap_errs` take the live counts that stood before that edge. The live counts restart at 0, plus the bit accepted at that same edge if there is one. The holding registers keep their value on every other edge.
- R8: Each counter stops at all ones and does not wrap.
- R9: Reset clears both holding registers and both live counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | 0 = pseudorandom, 1 = repeating word |
| cfg_len | input | 6 | Register length or word length, 1..32 |
| cfg_taps | input | 32 | Feedback taps; bit k selects the bit received k+1 beats earlier |
| in_valid | input | 1 | Received bit qualifier (gapped clock enable) |
| in_ready | output | 1 | Always 1 |
| in_bit | input | 1 | Received data bit |
| snap_strobe | input | 1 | Copy and clear counters |
| snap_bits | output | 32 | Compared-bit count of the last interval |
| snap_errs | output | 32 | Error count of the last interval |
| sync_lost | output | 1 | 1 whenever the reference is not locked |

## Verification
`sync_lost` is registered, so it changes at the same rising edge that takes the deciding bit. The bench samples it at the falling edge that follows, after at least one idle beat. The holding registers update at the edge that sees the strobe. The scoreboard monitor therefore delays the strobe by one register and pops its expected pair at the next falling edge, which is half a cycle after the values settle. Lock boundaries that can be computed exactly are checked on both sides: a one-bit repeating word locks on the 33rd bit and not on the 32nd, and a 7-stage sequence does not lock within 31 bits but does lock within 40. Error-window checks use a spacing of ten bits, so 5 errors fall in the window in one case and 6 in the other.

// File: rtl/prbs_chk_pkg.sv
`timescale 1ns/1ps
package prbs_chk_pkg;
  typedef enum logic {
    MODE_PRBS   = 1'b0,
    MODE_REPEAT = 1'b1
  } pat_mode_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_st_e;
endpackage

// File: rtl/prbs_ref_predictor.sv
`timescale 1ns/1ps
// Holds the recent history of the reference stream and predicts the next bit.
module prbs_ref_predictor
  import prbs_chk_pkg::*;
#(
  parameter int HIST_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              self_run,
  input  logic              rx_bit,
  input  logic              cfg_mode,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [HIST_W-1:0] cfg_taps,
  output logic              pred_bit
);
  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] len_mask;
  logic [HIST_W-1:0] len_pick;
  logic [HIST_W-1:0] taps_eff;
  pat_mode_e         mode;

  // Stage k holds the bit received k+1 beats ago.
  for (genvar k = 0; k < HIST_W; k++) begin : g_stage
    assign len_mask[k] = (LEN_W'(k) < cfg_len);
    assign len_pick[k] = (LEN_W'(k + 1) == cfg_len);
  end

  always_comb begin
    mode     = pat_mode_e'(cfg_mode);
    taps_eff = (mode == MODE_REPEAT) ? len_pick : (cfg_taps & len_mask);
  end

  assign pred_bit = ^(hist & taps_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (adv) begin
      hist <= {hist[HIST_W-2:0], self_run ? pred_bit : rx_bit};
    end
  end
endmodule

// File: rtl/prbs_lock_ctrl.sv
`timescale 1ns/1ps
// Acquisition run counter and sliding error window.
module prbs_lock_ctrl
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mismatch,
  output logic locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int ERR_W = $clog2(WIN + 1);

  sync_st_e         state;
  logic [RUN_W-1:0] run_cnt;
  logic [WIN-1:0]   win_hist;
  logic [ERR_W-1:0] win_errs;
  logic [ERR_W-1:0] win_next;
  logic             too_many;

  always_comb begin
    win_next = win_errs + ERR_W'(mismatch) - ERR_W'(win_hist[WIN-1]);
    too_many = (win_next >= ERR_W'(ERR_LIMIT));
  end

  assign locked = (state == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      run_cnt  <= '0;
      win_hist <= '0;
      win_errs <= '0;
    end else if (adv) begin
      case (state)
        ST_HUNT: begin
          if (mismatch) begin
            run_cnt <= '0;
          end else if (run_cnt == RUN_W'(LOCK_RUN - 1)) begin
            state    <= ST_LOCK;
            run_cnt  <= '0;
            win_hist <= '0;
            win_errs <= '0;
          end else begin
            run_cnt <= run_cnt + RUN_W'(1);
          end
        end
        default: begin
          if (too_many) begin
            state    <= ST_HUNT;
            run_cnt  <= '0;
            win_hist <= '0;
            win_errs <= '0;
          end else begin
            win_hist <= {win_hist[WIN-2:0], mismatch};
            win_errs <= win_next;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/prbs_bert_counters.sv
`timescale 1ns/1ps
// Saturating live counters with copy-and-clear holding registers.
module prbs_bert_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             err_en,
  input  logic             snap,
  output logic [CNT_W-1:0] live_bits,
  output logic [CNT_W-1:0] live_errs,
  output logic [CNT_W-1:0] hold_bits,
  output logic [CNT_W-1:0] hold_errs
);
  logic inc_b;
  logic inc_e;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic inc);
    return (inc && (v != '1)) ? v + CNT_W'(1) : v;
  endfunction

  assign inc_b = count_en;
  assign inc_e = count_en & err_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_bits <= '0;
      live_errs <= '0;
      hold_bits <= '0;
      hold_errs <= '0;
    end else if (snap) begin
      hold_bits <= live_bits;
      hold_errs <= live_errs;
      live_bits <= CNT_W'(inc_b);
      live_errs <= CNT_W'(inc_e);
    end else begin
      live_bits <= sat_inc(live_bits, inc_b);
      live_errs <= sat_inc(live_errs, inc_e);
    end
  end
endmodule

// File: rtl/prbs_sync_checker.sv
`timescale 1ns/1ps
module prbs_sync_checker #(
  parameter int HIST_W    = 32,
  parameter int CNT_W     = 32,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6,
  localparam int LEN_W    = $clog2(HIST_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [HIST_W-1:0] cfg_taps,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              snap_strobe,
  output logic [CNT_W-1:0]  snap_bits,
  output logic [CNT_W-1:0]  snap_errs,
  output logic              sync_lost
);
  logic             pred_bit;
  logic             mismatch;
  logic             locked;
  logic [CNT_W-1:0] live_bits;
  logic [CNT_W-1:0] live_errs;

  assign in_ready = 1'b1;
  assign mismatch = in_bit ^ pred_bit;

  prbs_ref_predictor #(
    .HIST_W (HIST_W),
    .LEN_W  (LEN_W)
  ) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (in_valid),
    .self_run (locked),
    .rx_bit   (in_bit),
    .cfg_mode (cfg_mode),
    .cfg_len  (cfg_len),
    .cfg_taps (cfg_taps),
    .pred_bit (pred_bit)
  );

  prbs_lock_ctrl #(
    .LOCK_RUN  (LOCK_RUN),
    .WIN       (WIN),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (in_valid),
    .mismatch (mismatch),
    .locked   (locked)
  );

  prbs_bert_counters #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (in_valid & locked),
    .err_en    (mismatch),
    .snap      (snap_strobe),
    .live_bits (live_bits),
    .live_errs (live_errs),
    .hold_bits (snap_bits),
    .hold_errs (snap_errs)
  );

  assign sync_lost = ~locked;
endmodule

// File: rtl/prbs_sync_checker_sva.sv
`timescale 1ns/1ps
module prbs_sync_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             snap_strobe,
  input logic             sync_lost,
  input logic [CNT_W-1:0] snap_bits,
  input logic [CNT_W-1:0] snap_errs,
  input logic [CNT_W-1:0] live_bits,
  input logic [CNT_W-1:0] live_errs
);
  // R1
  gap_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sync_lost));

  // R3
  lock_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lost) |-> $past(in_valid));

  // R4
  errs_within_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_errs <= live_bits);

  // R6
  hunt_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !snap_strobe) |=> ($stable(live_bits) && $stable(live_errs)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_strobe |=> ($stable(snap_bits) && $stable(snap_errs)));

  // R7
  live_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_strobe |=> (live_bits <= CNT_W'(1)));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((live_bits == '1) && !snap_strobe) |=> (live_bits == '1));
endmodule

bind prbs_sync_checker prbs_sync_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .snap_strobe (snap_strobe),
  .sync_lost   (sync_lost),
  .snap_bits   (snap_bits),
  .snap_errs   (snap_errs),
  .live_bits   (live_bits),
  .live_errs   (live_errs)
);

// File: tb/prbs_sync_checker_test.sv
`timescale 1ns/1ps
module prbs_sync_checker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode;
  logic [5:0]  cfg_len;
  logic [31:0] cfg_taps;
  logic        in_valid;
  logic        in_ready;
  logic        in_bit;
  logic        snap_strobe;
  logic [31:0] snap_bits;
  logic [31:0] snap_errs;
  logic        sync_lost;
  logic [7:0]  sat_bits;
  logic [7:0]  sat_errs;
  logic        sat_lost;
  logic        sat_ready;

  always #2.5 clk = ~clk;

  prbs_sync_checker uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .cfg_taps(cfg_taps), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .snap_strobe(snap_strobe), .snap_bits(snap_bits),
    .snap_errs(snap_errs), .sync_lost(sync_lost)
  );

  prbs_sync_checker #(.CNT_W(8)) sat_uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .cfg_taps(cfg_taps), .in_valid(in_valid), .in_ready(sat_ready),
    .in_bit(in_bit), .snap_strobe(snap_strobe), .snap_bits(sat_bits),
    .snap_errs(sat_errs), .sync_lost(sat_lost)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    longint unsigned bits;
    longint unsigned errs;
    string           tag;
  } exp_t;
  exp_t sbq[$];

  logic ign = 1'b1;
  logic snap_d = 1'b0;
  logic ign_d = 1'b1;

  // transmit-side model
  logic [6:0]  ph;
  logic [31:0] rep_pat;
  int          rep_len;
  int          rep_idx;
  bit          use_rep;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic gen_next();
    logic b;
    if (use_rep) begin
      b = rep_pat[rep_idx];
      rep_idx = (rep_idx + 1) % rep_len;
    end else begin
      b  = ph[6] ^ ph[5];
      ph = {ph[5:0], b};
    end
    return b;
  endfunction

  task automatic step(logic v, logic b, logic s);
    @(negedge clk);
    in_valid    = v;
    in_bit      = b;
    snap_strobe = s;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic send(int n, int first, int every);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = gen_next();
      if (every > 0 && i >= first && ((i - first) % every) == 0) b = ~b;
      step(1'b1, b, 1'b0);
    end
  endtask

  task automatic expect_snap(longint unsigned b, longint unsigned e, string tag);
    exp_t x;
    x.bits = b; x.errs = e; x.tag = tag;
    sbq.push_back(x);
    ign = 1'b0;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear_snap();
    ign = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic m, logic [5:0] l, logic [31:0] t);
    rst_n = 1'b0;
    cfg_mode = m; cfg_len = l; cfg_taps = t;
    in_valid = 1'b0; in_bit = 1'b0; snap_strobe = 1'b0;
    ph = 7'h01; rep_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    snap_d <= snap_strobe;
    ign_d  <= ign;
  end

  always @(negedge clk) begin
    if (snap_d && !ign_d) begin
      if (sbq.size() == 0) begin
        chk("R7", "unexpected snapshot", 1, 0);
      end else begin
        exp_t x;
        x = sbq.pop_front();
        chk(x.tag, "snap_bits", snap_bits, x.bits);
        chk(x.tag, "snap_errs", snap_errs, x.errs);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    use_rep = 1'b0; rep_pat = '0; rep_len = 1;
    // 7-stage sequence, taps on bits received 7 and 6 beats ago
    do_reset(1'b0, 6'd7, 32'h0000_0060);
    @(negedge clk);
    chk("R9", "reset snap_bits", snap_bits, 0);
    chk("R9", "reset snap_errs", snap_errs, 0);
    chk("R3", "reset sync_lost", sync_lost, 1);
    chk("R1", "in_ready", in_ready, 1);

    // R3: no lock within 31 bits, lock within 40
    send(31, 0, 0); idle();
    chk("R3", "sync_lost after 31 bits", sync_lost, 1);
    send(9, 0, 0); idle();
    chk("R3", "sync_lost after 40 bits", sync_lost, 0);
    chk("R2", "narrow instance locked", sat_lost, 0);

    // R4: three single-bit errors
    clear_snap();
    send(100, 19, 30);
    expect_snap(100, 3, "R4");
    chk("R4", "lock kept", sync_lost, 0);

    // R1: gapped beats carry garbage
    for (int i = 0; i < 20; i++) begin
      logic b;
      step(1'b0, logic'(i[0]), 1'b0);
      b = gen_next();
      step(1'b1, b, 1'b0);
    end
    expect_snap(20, 0, "R1");
    chk("R1", "lock kept through gaps", sync_lost, 0);

    // R7: strobe on the same edge as a valid bit
    send(10, 0, 0);
    begin
      exp_t x;
      logic b;
      x.bits = 10; x.errs = 0; x.tag = "R7";
      sbq.push_back(x);
      ign = 1'b0;
      b = gen_next();
      step(1'b1, b, 1'b1);
    end
    send(4, 0, 0);
    expect_snap(5, 0, "R7");

    // R5: five errors in the window keep lock, six drop it
    send(50, 9, 10); idle();
    chk("R5", "five errors keep lock", sync_lost, 0);
    expect_snap(50, 5, "R5");
    send(70, 0, 0);
    expect_snap(70, 0, "R5");
    send(60, 9, 10); idle();
    chk("R5", "six errors drop lock", sync_lost, 1);
    expect_snap(60, 6, "R5");

    // R6: nothing counted while hunting
    send(10, 0, 0);
    expect_snap(0, 0, "R6");

    // R8: narrow instance saturates
    send(40, 0, 0); idle();
    chk("R3", "relock", sync_lost, 0);
    clear_snap();
    send(300, 0, 0);
    expect_snap(300, 0, "R8");
    chk("R8", "narrow snap_bits saturated", sat_bits, 255);
    chk("R8", "narrow snap_errs", sat_errs, 0);

    // R3 exact boundary with a one-bit word of ones
    use_rep = 1'b1; rep_pat = 32'hFFFF_FFFF; rep_len = 1;
    do_reset(1'b1, 6'd1, 32'h0);
    send(32, 0, 0); idle();
    chk("R3", "len1 after 32 bits", sync_lost, 1);
    send(1, 0, 0); idle();
    chk("R3", "len1 after 33 bits", sync_lost, 0);

    // R2: five-bit repeating word
    rep_pat = 32'h0000_000D; rep_len = 5;
    do_reset(1'b1, 6'd5, 32'h0);
    send(40, 0, 0); idle();
    chk("R2", "len5 locked", sync_lost, 0);
    clear_snap();
    send(40, 4, 15);
    expect_snap(40, 3, "R2");

    // R2: full 32-bit repeating word
    rep_pat = 32'hA5C3_0F96; rep_len = 32;
    do_reset(1'b1, 6'd32, 32'h0);
    send(64, 0, 0); idle();
    chk("R2", "len32 locked", sync_lost, 0);
    clear_snap();
    send(50, 0, 25);
    expect_snap(50, 2, "R2");

    idle(); idle();
    chk("R7", "scoreboard drained", sbq.size(), 0);
    report();
    $finish;
  end
endmodule